// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire serial link: an active-high select, a serial clock and a single data line that changes direction partway through a transfer. Through it a host reaches a 128-entry register space that lives outside the block. Each transfer carries one command byte, then one data byte. The command byte holds a 7-bit register address and a direction bit. The data byte then travels toward the device for a write or back to the host for a read.

All three link inputs are resynchronised to the system clock and sampled there, so the serial clock must stay well below the system clock. Each serial clock level has to last at least eight system clock cycles. The register side has two paths. For reads, `rd_addr` is presented and `rd_data` must answer combinationally within one system clock. Writes leave through a valid/ready offer. Once raised, `wr_valid` holds `wr_addr` and `wr_data` steady until a cycle where `wr_ready` is high. That cycle completes the handshake. A write that finishes over the link while an earlier offer is still waiting is discarded, because the link itself cannot be stalled. The block also raises a one-cycle strobe whenever an alarm register is touched, so the clock core can clear its interrupt request flag. Accesses are refused while the `access_ok` input is low. The power-monitoring logic holds it low below the supply trip point and through the power-up delay.

Top module: `sreg_port`

## Requirements
- R1: A transfer begins with the command byte, sent least significant bit first and sampled on rising serial clock edges. Bits 0 to 6 are the register address. Bit 7 set to 1 selects a write and bit 7 cleared to 0 selects a read.
- R2: On a read, the eight data bits appear on `sdio_out` least significant bit first, with `sdio_oe` high. Each bit is driven after a falling serial clock edge, starting with the falling edge that follows the eighth command bit. The value is `rd_data` answered for `rd_addr`, which equals the command address.
- R3: Addresses 0x0F through 0x7F are reserved. A read of one returns 0x00 whatever `rd_data` holds. A write to one is never offered on the write port.
- R4: A write is offered only after all eight data bits have been clocked in with the select still high. A transfer cut short by the select falling produces no offer.
- R5: Each access to addresses 0x07 through 0x0A, read or write, produces exactly one single-cycle `alarm_clr` pulse once the command byte is complete. Accesses to any other address produce none.
- R6: A low select at any point releases the data line (`sdio_oe` low) and returns the bit count to zero. The next transfer therefore starts cleanly at command bit 0.
- R7: While `access_ok` is low the link is ignored. The data line is not driven, no write is offered and no alarm strobe is produced.
- R8: A pending write offer keeps `wr_addr` and `wr_data` stable until `wr_ready` is seen. A write completed on the link while an earlier offer is still unaccepted is dropped.
- R9: After reset, `sdio_oe`, `wr_valid` and `alarm_clr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| access_ok | input | 1 | High when supply and power-up conditions permit access |
| cs | input | 1 | Serial select, active high |
| sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Data value driven onto the line during reads |
| sdio_oe | output | 1 | High while the block drives the data line |
| rd_addr | output | 7 | Address of the register being read |
| rd_data | input | 8 | Register content for `rd_addr`, combinational |
| wr_valid | output | 1 | Write offer pending |
| wr_ready | input | 1 | Register side accepts the write offer |
| wr_addr | output | 7 | Address of the offered write |
| wr_data | output | 8 | Data of the offered write |
| alarm_clr | output | 1 | One-cycle strobe on any alarm register access |

## Verification
Random transfers draw their addresses from three pools: ordinary registers, the four alarm registers and the whole map, where most addresses are reserved. Both directions are used. This separates correct address decoding from a reversed direction bit or a wrong reserved boundary, and shows that the alarm strobe fires only for its window. Directed transfers cover the remaining behaviours: a select dropped partway through the data byte (no write may appear), a select dropped inside the command byte (the following read must still decode), a transfer with access refused (no drive, no write, no strobe), and a write completed while the register side withholds ready (the first offer must stay stable and the second must be dropped).

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input int lo, input int hi);
    return (int'(a) >= lo) && (int'(a) <= hi);
  endfunction
endpackage

// File: rtl/sreg_port_sync.sv
module sreg_port_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_in;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/sreg_port_decode.sv
module sreg_port_decode
  import sreg_port_pkg::*;
#(
  parameter int RESV_LO = 15,
  parameter int ALM_LO  = 7,
  parameter int ALM_HI  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              reserved,
  output logic              alarm_hit
);
  localparam int TOP = (1 << ADDR_W) - 1;

  always_comb begin
    reserved  = in_window(addr, RESV_LO, TOP);
    alarm_hit = in_window(addr, ALM_LO, ALM_HI);
  end
endmodule

// File: rtl/sreg_port_engine.sv
module sreg_port_engine
  import sreg_port_pkg::*;
#(
  parameter int RESV_LO = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              cmd_resv,
  input  logic              cmd_alarm,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              dout,
  output logic              oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              alarm_clr
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int TOT   = CMD_W + DATA_W;
  localparam int CW    = $clog2(TOT + 1);

  logic              sclk_d;
  logic              rise, fall;
  logic [CW-1:0]     cnt;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] wsh, rsh;
  logic              cmd_done;
  logic              is_wr;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign is_wr    = cmd_q[CMD_W-1];
  assign cmd_addr = cmd_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; cnt <= '0; cmd_q <= '0; wsh <= '0; rsh <= '0;
      cmd_done <= 1'b0; dout <= 1'b0; oe <= 1'b0; alarm_clr <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      sclk_d    <= sclk_s;
      cmd_done  <= 1'b0;
      alarm_clr <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (!gate) begin
        cnt  <= '0;
        oe   <= 1'b0;
        dout <= 1'b0;
      end else begin
        if (rise && cnt < CW'(TOT)) begin
          cnt <= cnt + 1'b1;
          if (cnt < CW'(CMD_W)) cmd_q <= {din_s, cmd_q[CMD_W-1:1]};
          else                  wsh   <= {din_s, wsh[DATA_W-1:1]};
          if (cnt == CW'(CMD_W - 1)) cmd_done <= 1'b1;
          if (cnt == CW'(TOT - 1) && is_wr && !cmd_resv && !(wr_valid && !wr_ready)) begin
            wr_valid <= 1'b1;
            wr_addr  <= cmd_addr;
            wr_data  <= {din_s, wsh[DATA_W-1:1]};
          end
        end
        if (cmd_done) begin
          alarm_clr <= cmd_alarm;
          rsh       <= cmd_resv ? '0 : rd_data;
        end
        if (fall && cnt >= CW'(CMD_W) && cnt < CW'(TOT) && !is_wr) begin
          oe   <= 1'b1;
          dout <= rsh[0];
          rsh  <= rsh >> 1;
        end
      end
    end
  end

  a_r2_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !is_wr);
  a_r3_no_reserved_offer: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (int'(wr_addr) < RESV_LO));
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr |=> !alarm_clr);
  a_r6_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (!oe && cnt == '0));
  a_r8_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESV_LO     = 15,
  parameter int ALM_LO      = 7,
  parameter int ALM_HI      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_ok,
  input  logic              cs,
  input  logic              sclk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              alarm_clr
);
  logic [2:0] pins_s;
  logic       gate, resv, alarm_hit;

  sreg_port_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({cs, sclk, sdio_in}), .d_out(pins_s));

  assign gate = pins_s[2] & access_ok;

  sreg_port_decode #(.RESV_LO(RESV_LO), .ALM_LO(ALM_LO), .ALM_HI(ALM_HI)) u_dec (
    .addr(rd_addr), .reserved(resv), .alarm_hit(alarm_hit));

  sreg_port_engine #(.RESV_LO(RESV_LO)) u_eng (
    .clk(clk), .rst_n(rst_n), .gate(gate), .sclk_s(pins_s[1]), .din_s(pins_s[0]),
    .cmd_resv(resv), .cmd_alarm(alarm_hit), .rd_data(rd_data), .wr_ready(wr_ready),
    .cmd_addr(rd_addr), .dout(sdio_out), .oe(sdio_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .alarm_clr(alarm_clr));

  a_r7_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ok |=> (!alarm_clr && !sdio_oe));
endmodule

// File: tb/sreg_port_tb.sv
module sreg_port_tb;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, access_ok = 1, cs = 0, sclk = 0, sdio_in = 0;
  logic wr_ready = 1;
  logic sdio_out, sdio_oe, wr_valid, alarm_clr;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  int checks = 0, fails = 0;
  int n_wr = 0, n_alm = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;
  logic [7:0] got;
  logic oe_seen;

  always #5 clk = ~clk;

  function automatic logic [7:0] model_rd(input logic [6:0] a);
    return 8'({1'b0, a} * 8'd29) ^ 8'h5A;
  endfunction
  function automatic logic is_resv(input logic [6:0] a); return a >= 7'h0F; endfunction
  function automatic logic is_alm(input logic [6:0] a); return a >= 7'h07 && a <= 7'h0A; endfunction

  assign rd_data = model_rd(rd_addr);

  sreg_port u_dut (.clk(clk), .rst_n(rst_n), .access_ok(access_ok), .cs(cs), .sclk(sclk),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .alarm_clr(alarm_clr));

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin n_wr++; last_wa = wr_addr; last_wd = wr_data; end
    if (alarm_clr) n_alm++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits: how many clock bits to send before dropping select
  task automatic xfer(input logic wr, input logic [6:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] bits;
    bits = {d, wr, a};
    got = 8'h00; oe_seen = 0;
    @(negedge clk); cs = 1; wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdio_in = bits[i];
      wait_clk(HALF);
      if (i >= 8) begin got[i-8] = sdio_out; oe_seen = oe_seen | sdio_oe; end
      sclk = 1; wait_clk(HALF);
      sclk = 0;
      if (sdio_oe) oe_seen = 1;
    end
    wait_clk(HALF);
    if (sdio_oe) oe_seen = 1;
    cs = 0; sdio_in = 0; wait_clk(HALF);
  endtask

  initial begin
    wait_clk(150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int w0, a0;
    void'($urandom(32'd4242));
    wait_clk(4);
    check("R9 oe", sdio_oe, 0); check("R9 wr_valid", wr_valid, 0); check("R9 alarm", alarm_clr, 0);
    rst_n = 1; wait_clk(4);

    // directed: plain write and read of an ordinary register
    w0 = n_wr;
    xfer(1, 7'h03, 8'hC6, 16);
    check("R1 write count", n_wr, w0 + 1); check("R1 write addr", last_wa, 7'h03);
    check("R1 write data", last_wd, 8'hC6);
    xfer(0, 7'h05, 8'h00, 16);
    check("R2 read data", got, model_rd(7'h05)); check("R2 drive", oe_seen, 1);
    check("R6 released", sdio_oe, 0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [6:0] a; logic [7:0] d; logic wr; int sel;
      sel = $urandom % 3;
      a = (sel == 0) ? 7'($urandom % 15) : (sel == 1) ? 7'(7 + $urandom % 4) : 7'($urandom);
      d = 8'($urandom); wr = 1'($urandom);
      w0 = n_wr; a0 = n_alm;
      xfer(wr, a, d, 16);
      if (wr) begin
        if (is_resv(a)) check("R3 reserved write dropped", n_wr, w0);
        else begin
          check("R1 random write count", n_wr, w0 + 1);
          check("R1 random write addr", last_wa, a); check("R1 random write data", last_wd, d);
        end
      end else
        check(is_resv(a) ? "R3 reserved read zero" : "R2 random read", got,
              is_resv(a) ? 8'h00 : model_rd(a));
      check("R5 alarm count", n_alm, a0 + (is_alm(a) ? 1 : 0));
    end

    // boundary addresses
    xfer(0, 7'h0E, 0, 16); check("R3 last usable read", got, model_rd(7'h0E));
    xfer(0, 7'h0F, 0, 16); check("R3 first reserved read", got, 8'h00);
    a0 = n_alm; xfer(0, 7'h06, 0, 16); xfer(0, 7'h0B, 0, 16);
    check("R5 outside window", n_alm, a0);

    // abort during data byte
    w0 = n_wr; xfer(1, 7'h02, 8'h77, 13); check("R4 aborted write", n_wr, w0);
    // abort inside command byte, then a clean read
    xfer(1, 7'h7F, 0, 3); check("R6 no drive after abort", sdio_oe, 0);
    xfer(0, 7'h09, 0, 16); check("R6 read after abort", got, model_rd(7'h09));

    // refused access
    access_ok = 0; w0 = n_wr; a0 = n_alm;
    xfer(0, 7'h08, 0, 16); check("R7 no drive", oe_seen, 0);
    xfer(1, 7'h08, 8'h11, 16); check("R7 no write", n_wr, w0); check("R7 no strobe", n_alm, a0);
    access_ok = 1;

    // back-pressure
    wr_ready = 0; w0 = n_wr;
    xfer(1, 7'h01, 8'hA5, 16);
    check("R8 offer held", wr_valid, 1); check("R8 offer addr", wr_addr, 7'h01);
    xfer(1, 7'h04, 8'h3C, 16);
    check("R8 first offer kept", wr_data, 8'hA5);
    @(negedge clk); wr_ready = 1; wait_clk(3);
    check("R8 one accepted", n_wr, w0 + 1); check("R8 accepted data", last_wd, 8'hA5);
    check("R8 second dropped", wr_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule